// File: doc/BRIEF.md
# Interconnect Request Event Counter Unit

This block watches the request port of a coherent interconnect node. It counts requests by class in four 32-bit counters. On each cycle the port offers a valid strobe and a 3-bit class code. Each counter follows one class, or none.

Software drives a simple word-addressed register bus. Through it, software:
- writes a packed select word that gives each counter its event, one byte per counter;
- sets or clears a global enable bit in a control word;
- preloads or reads any counter.

Counters wrap silently at 2^32. On each wrap, a one-cycle overflow pulse goes out for that counter.

Register map, as byte offsets with aligned 32-bit words:
- 0x00 holds the select word.
- 0x04 holds the control word.
- 0x10 + 4·n holds counter n.

Reads are combinational on the address. Writes take effect at the next clock edge.

Top module: `req_evt_pmu`

## Requirements
- R1: After reset the select word reads 0xFFFFFFFF, the control word reads 0, and every counter reads 0.
- R2: The select byte at bits [8n+7:8n] of the select word (offset 0x00) chooses the event for counter n. A write to the select word is read back unchanged.
- R3: Event codes are: 0 ordered barrier, 1 non-ordered barrier, 2 DVM operation, 3 DVM sync, 4 read, 5 write, 6 copy-back, 7 other. Counter n increments by one at each clock edge where enable is set, the request strobe is high, and the class code equals its select byte.
- R4: A select byte of 0xFF marks the counter free. Values 8 to 0xFE match no event. Such a counter never increments.
- R5: Bit 0 of the control word (offset 0x04) is the enable; while it is 0 no counter changes. All 32 bits of the control word are stored and read back, so a read-modify-write of bit 0 keeps the other bits.
- R6: Counter n sits at byte offset 0x10 + 4·n. A write there preloads the value, and a read returns the live count.
- R7: A counter at 0xFFFFFFFF that increments becomes 0 without any other effect on its value. Its ovf_o bit is high for exactly the one cycle after that edge.
- R8: When a bus write to a counter and an increment of that counter fall on the same edge, the written value is stored.
- R9: When several counters select the same code, a matching request increments all of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 8 | Register byte address |
| bus_wdata_i | input | 32 | Register write data |
| bus_rdata_o | output | 32 | Register read data for bus_addr_i; 0 for unmapped addresses |
| req_valid_i | input | 1 | A request is present on the node port this cycle |
| req_class_i | input | 3 | Class code of the request |
| ovf_o | output | 4 | Per-counter wrap pulse |

## Verification
The hardest case to reach from the ports is the wrap: reaching 0xFFFFFFFF by counting would take billions of cycles. The bench instead preloads a counter to 0xFFFFFFFE and steps it with single matching requests. It checks the value and the overflow pulse on each side of the wrap. The collision of a bus write and an increment on one edge is built by driving the write strobe and a matching request in the same cycle.

// File: rtl/req_evt_pkg.sv
package req_evt_pkg;
  localparam int NUM_CNT = 4;
  localparam int DATA_W  = 32;
  localparam int SEL_W   = 8;
  localparam int CLS_W   = 3;
  localparam int ADDR_W  = 8;

  localparam logic [ADDR_W-1:0] SEL_OFF  = 8'h00;
  localparam logic [ADDR_W-1:0] CTRL_OFF = 8'h04;
  localparam logic [ADDR_W-1:0] CNT_OFF  = 8'h10;

  typedef enum logic [CLS_W-1:0] {
    CLS_ORD_BARRIER  = 3'd0,
    CLS_NORD_BARRIER = 3'd1,
    CLS_DVM_OP       = 3'd2,
    CLS_DVM_SYNC     = 3'd3,
    CLS_READ         = 3'd4,
    CLS_WRITE        = 3'd5,
    CLS_COPYBACK     = 3'd6,
    CLS_OTHER        = 3'd7
  } req_class_e;
endpackage

// File: rtl/req_evt_match.sv
module req_evt_match #(
  parameter int SEL_W = req_evt_pkg::SEL_W,
  parameter int CLS_W = req_evt_pkg::CLS_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             en_i,
  input  logic             valid_i,
  input  logic [CLS_W-1:0] class_i,
  output logic             hit_o
);
  logic in_range;

  // upper select bits nonzero covers 0xFF and every other unused code
  assign in_range = (sel_i[SEL_W-1:CLS_W] == '0);
  assign hit_o    = en_i && valid_i && in_range && (sel_i[CLS_W-1:0] == class_i);

  // R4
  free_never_hits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == '1) |-> !hit_o);
endmodule

// File: rtl/req_evt_counter.sv
module req_evt_counter #(
  parameter int CNT_W = req_evt_pkg::DATA_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      ovf_q <= inc_i && !load_i && (cnt_q == '1);
      if (load_i)     cnt_q <= load_val_i;
      else if (inc_i) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o = cnt_q;
  assign ovf_o = ovf_q;

  // R8
  load_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == $past(load_val_i)));
  // R7
  wrap_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_q |-> (cnt_q == '0));
  // R3
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !inc_i) |=> $stable(cnt_q));
endmodule

// File: rtl/req_evt_regs.sv
module req_evt_regs #(
  parameter int NUM_CNT = req_evt_pkg::NUM_CNT,
  parameter int DATA_W  = req_evt_pkg::DATA_W,
  parameter int ADDR_W  = req_evt_pkg::ADDR_W
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           we_i,
  input  logic [ADDR_W-1:0]              addr_i,
  input  logic [DATA_W-1:0]              wdata_i,
  input  logic [NUM_CNT-1:0][DATA_W-1:0] cnt_i,
  output logic [DATA_W-1:0]              rdata_o,
  output logic [DATA_W-1:0]              sel_o,
  output logic                           en_o,
  output logic [NUM_CNT-1:0]             load_o
);
  import req_evt_pkg::*;

  logic [DATA_W-1:0]  sel_q, ctrl_q;
  logic               sel_we, ctrl_we;
  logic [NUM_CNT-1:0] cnt_hit;

  assign sel_we  = we_i && (addr_i == SEL_OFF);
  assign ctrl_we = we_i && (addr_i == CTRL_OFF);

  for (genvar n = 0; n < NUM_CNT; n++) begin : g_dec
    localparam logic [ADDR_W-1:0] OFF = CNT_OFF + ADDR_W'(4 * n);
    assign cnt_hit[n] = (addr_i == OFF);
    assign load_o[n]  = we_i && cnt_hit[n];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q  <= '1;
      ctrl_q <= '0;
    end else begin
      if (sel_we)  sel_q  <= wdata_i;
      if (ctrl_we) ctrl_q <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == SEL_OFF)  rdata_o = sel_q;
    if (addr_i == CTRL_OFF) rdata_o = ctrl_q;
    for (int n = 0; n < NUM_CNT; n++)
      if (cnt_hit[n]) rdata_o = cnt_i[n];
  end

  assign sel_o = sel_q;
  assign en_o  = ctrl_q[0];

  // R5
  ctrl_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_we |=> $stable(ctrl_q));
  // R6
  single_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(load_o));
endmodule

// File: rtl/req_evt_pmu.sv
module req_evt_pmu #(
  parameter int NUM_CNT = req_evt_pkg::NUM_CNT,
  parameter int DATA_W  = req_evt_pkg::DATA_W,
  parameter int SEL_W   = req_evt_pkg::SEL_W,
  parameter int CLS_W   = req_evt_pkg::CLS_W,
  parameter int ADDR_W  = req_evt_pkg::ADDR_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               bus_we_i,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic [DATA_W-1:0]  bus_wdata_i,
  output logic [DATA_W-1:0]  bus_rdata_o,
  input  logic               req_valid_i,
  input  logic [CLS_W-1:0]   req_class_i,
  output logic [NUM_CNT-1:0] ovf_o
);
  logic [NUM_CNT-1:0][DATA_W-1:0] cnt;
  logic [DATA_W-1:0]              sel;
  logic                           en;
  logic [NUM_CNT-1:0]             load, hit;

  req_evt_regs #(.NUM_CNT(NUM_CNT), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) regs_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (bus_we_i),
    .addr_i  (bus_addr_i),
    .wdata_i (bus_wdata_i),
    .cnt_i   (cnt),
    .rdata_o (bus_rdata_o),
    .sel_o   (sel),
    .en_o    (en),
    .load_o  (load)
  );

  for (genvar n = 0; n < NUM_CNT; n++) begin : g_cnt
    req_evt_match #(.SEL_W(SEL_W), .CLS_W(CLS_W)) match_i (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .sel_i   (sel[n*SEL_W +: SEL_W]),
      .en_i    (en),
      .valid_i (req_valid_i),
      .class_i (req_class_i),
      .hit_o   (hit[n])
    );

    req_evt_counter #(.CNT_W(DATA_W)) counter_i (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .load_i     (load[n]),
      .load_val_i (bus_wdata_i),
      .inc_i      (hit[n]),
      .cnt_o      (cnt[n]),
      .ovf_o      (ovf_o[n])
    );
  end

  // R5
  disabled_no_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |-> (hit == '0));
  // R3
  idle_port_no_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |-> (hit == '0));
endmodule

// File: tb/req_evt_pmu_tb_top.sv
module req_evt_pmu_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        req_valid = 1'b0;
  logic [2:0]  req_class = '0;
  logic [3:0]  ovf;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  req_evt_pmu dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .bus_we_i(bus_we), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .req_valid_i(req_valid),
    .req_class_i(req_class), .ovf_o(ovf)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic reg_wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic reg_rd(logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic send(logic [2:0] c, int cnt);
    for (int i = 0; i < cnt; i++) begin
      @(negedge clk);
      req_valid = 1'b1; req_class = c;
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic chk_cnt(string req, int n, logic [31:0] exp);
    logic [31:0] d;
    reg_rd(8'h10 + 8'(4 * n), d);
    check(req, d, exp);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    reg_rd(8'h00, d); check("R1 select", d, 32'hFFFF_FFFF);
    reg_rd(8'h04, d); check("R1 control", d, 32'h0);
    for (int n = 0; n < 4; n++) chk_cnt("R1 counter", n, 32'h0);
    check("R1 ovf", {28'h0, ovf}, 32'h0);
  endtask

  task automatic t_free;
    reg_wr(8'h04, 32'h1);
    for (int c = 0; c < 8; c++) send(3'(c), 1);
    for (int n = 0; n < 4; n++) chk_cnt("R4 free counter", n, 32'h0);
  endtask

  task automatic t_assign;
    logic [31:0] d;
    reg_wr(8'h00, 32'h0704_0100);
    reg_rd(8'h00, d); check("R2 select readback", d, 32'h0704_0100);
    send(3'd4, 3); send(3'd0, 2); send(3'd7, 1); send(3'd1, 5);
    send(3'd2, 2); send(3'd6, 1);
    chk_cnt("R3 code0 lane0", 0, 32'd2);
    chk_cnt("R3 code1 lane1", 1, 32'd5);
    chk_cnt("R3 code4 lane2", 2, 32'd3);
    chk_cnt("R3 code7 lane3", 3, 32'd1);
  endtask

  task automatic t_range;
    for (int n = 0; n < 4; n++) reg_wr(8'h10 + 8'(4 * n), 32'h0);
    reg_wr(8'h00, 32'h0000_FE08);
    for (int c = 0; c < 8; c++) send(3'(c), 1);
    chk_cnt("R4 select 0x08", 0, 32'd0);
    chk_cnt("R4 select 0xFE", 1, 32'd0);
    chk_cnt("R9 shared code c2", 2, 32'd1);
    chk_cnt("R9 shared code c3", 3, 32'd1);
  endtask

  task automatic t_enable;
    logic [31:0] d;
    reg_wr(8'h04, 32'hA5A5_0000);
    reg_rd(8'h04, d); check("R5 ctrl readback", d, 32'hA5A5_0000);
    send(3'd0, 2);
    chk_cnt("R5 disabled", 2, 32'd1);
    reg_rd(8'h04, d);
    reg_wr(8'h04, d | 32'h1);
    reg_rd(8'h04, d); check("R5 rmw preserve", d, 32'hA5A5_0001);
    send(3'd0, 1);
    chk_cnt("R5 enabled", 2, 32'd2);
  endtask

  task automatic t_wrap;
    reg_wr(8'h00, 32'hFFFF_05FF);
    reg_wr(8'h14, 32'hFFFF_FFFE);
    chk_cnt("R6 preload", 1, 32'hFFFF_FFFE);
    send(3'd5, 1);
    chk_cnt("R6 live count", 1, 32'hFFFF_FFFF);
    check("R7 no early ovf", {28'h0, ovf}, 32'h0);
    send(3'd5, 1);
    chk_cnt("R7 wrap value", 1, 32'h0);
    check("R7 ovf pulse", {28'h0, ovf}, 32'h2);
    @(negedge clk);
    check("R7 ovf one cycle", {28'h0, ovf}, 32'h0);
  endtask

  task automatic t_collide;
    reg_wr(8'h00, 32'hFF03_FFFF);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 8'h18; bus_wdata = 32'h100;
    req_valid = 1'b1; req_class = 3'd3;
    @(negedge clk);
    bus_we = 1'b0; req_valid = 1'b0;
    chk_cnt("R8 write wins", 2, 32'h100);
    send(3'd3, 1);
    chk_cnt("R8 count after write", 2, 32'h101);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_free();
    t_assign();
    t_range();
    t_enable();
    t_wrap();
    t_collide();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule